// File: doc/BRIEF.md
# Two-Channel Filtered Quadrature Position Counter

This block turns two incremental encoders into two signed-free position counts. Each channel takes an in-phase line (I) and a quadrature line (Q). Both lines are resynchronised to the system clock and passed through a glitch filter that only accepts a new level after it has held for two samples. The filtered pair is then decoded with a 4x Gray-code table, and the result drives an up/down counter. All sampling is paced by a clock enable from a programmable divider, which runs between one sample every 2 clocks and one sample every 512 clocks.

Software uses a small register interface. It picks each channel's input nibble or turns the channel off, selects an 8-bit or 10-bit count width, sets the sampling rate and reads back the counts. A wrap of either counter sets a sticky status flag and raises a level interrupt. Reading the status register clears both. Writing the status register zeroes both counters.

Register map, selected by `reg_addr`:
- 0 is status/command. A read returns `{4'b0, ch1_under, ch1_over, ch0_under, ch0_over}` and clears those flags. A write clears both counters.
- 1 is configuration: bits[2:0] are the channel 0 source, bits[5:3] the channel 1 source, and bit[6] selects 10-bit width.
- 2 is the divider constant TC.
- 3 and 4 are the channel 0 count low byte and the count bits [9:8].
- 5 and 6 are the same two registers for channel 1.

Source codes:
- Codes 0 to 3 disable the channel.
- 3'b100 selects port A bits[3:0] and 3'b101 selects port A bits[7:4].
- 3'b110 selects port B bits[3:0] and 3'b111 selects port B bits[7:4].
- Within a selected nibble, I is the odd bit (nibble bit 1) and Q is the even bit (nibble bit 0).

Top module: `qdec_top`

## Requirements
- R1: After reset, both counts, all status flags and `irq` are zero, and both channels are disabled.
- R2: In the forward order, {I,Q} goes 00→10→11→01→00. Each filtered transition in this order increments the count by one, and each transition in the reverse order decrements it by one.
- R3: A sample in which I and Q both change leaves the count unchanged.
- R4: A new input level is accepted only after it is seen on two consecutive enabled samples. A level held for a single sample never changes the count.
- R5: Samples are taken once every 2·(TC+1) clocks, where TC is register 2. This gives a rate between clk/2 and clk/512, and inputs between samples are not seen.
- R6: Configuration bit 6 selects the width. At 0 the count is 8 bits and wraps at 0xFF, and the high register reads 0. At 1 the count is 10 bits and wraps at 0x3FF. The high register returns count[9:8] in bits[1:0], and its bits[7:2] read as zero.
- R7: An increment from the all-ones value to zero sets the channel's overflow flag, and a decrement from zero to all-ones sets its underflow flag. The flags use status bits 0/1 for channel 0 and bits 2/3 for channel 1. `irq` is high whenever any flag is set, starting the cycle the flag is set.
- R8: A read of register 0 returns the flags and then clears every flag and `irq`, unless a new wrap happens in that same cycle.
- R9: A write to register 0 clears both counters.
- R10: A disabled channel holds its count whatever its inputs do. Entering or leaving the disabled state, or switching source, never changes the count.
- R11: The two channels count independently, each from its own selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a | input | 8 | Encoder input port A (asynchronous) |
| port_b | input | 8 | Encoder input port B (asynchronous) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on register 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded properties check several things on every cycle:
- Sampling ticks are never adjacent.
- A filter output moves only on a tick, and never on the first sample of a new level.
- A count moves by at most one step per cycle and stays still while its channel is disabled.
- In 8-bit mode the count's upper bits stay clear.
- A wrap always raises `irq`, and a status read with no new wrap always clears it.

Only the directed scenarios can show the following:
- The Gray-code direction, and the rejection of illegal double changes.
- The exact divider rate and the single-sample glitch rejection at the ports.
- The wrap values in both widths, and the separation of the two channels.
- That leaving the disabled state with a changed input produces no count.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

   // Source select encoding: bit2 = enable, bit1 = port B, bit0 = upper nibble
   typedef enum logic [2:0] {
      SRC_OFF   = 3'b000,
      SRC_A_LO  = 3'b100,
      SRC_A_HI  = 3'b101,
      SRC_B_LO  = 3'b110,
      SRC_B_HI  = 3'b111
   } qd_src_e;

   typedef enum logic [1:0] {
      DIR_NONE = 2'b00,
      DIR_UP   = 2'b01,
      DIR_DOWN = 2'b10
   } qd_dir_e;

   // Position of an {I,Q} pair in the forward Gray cycle 00,10,11,01
   function automatic logic [1:0] gray_pos(input logic [1:0] iq);
      case (iq)
         2'b00:   gray_pos = 2'd0;
         2'b10:   gray_pos = 2'd1;
         2'b11:   gray_pos = 2'd2;
         default: gray_pos = 2'd3;
      endcase
   endfunction

   function automatic qd_dir_e gray_dir(input logic [1:0] prev, input logic [1:0] cur);
      logic [1:0] d;
      d = gray_pos(cur) - gray_pos(prev);
      case (d)
         2'd1:    gray_dir = DIR_UP;
         2'd3:    gray_dir = DIR_DOWN;
         default: gray_dir = DIR_NONE;   // no change or illegal double step
      endcase
   endfunction

endpackage

// File: rtl/qdec_tick.sv
module qdec_tick #(
   parameter int TC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TC_W-1:0] tc,
   output logic            tick
);
   localparam int CW = TC_W + 1;

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == '0);

   // Period is 2*(tc+1) clocks: reload with 2*tc+1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick)   cnt_q <= {tc, 1'b1};
      else             cnt_q <= cnt_q - 1'b1;
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);  // R5

endmodule

// File: rtl/qdec_glitch.sv
module qdec_glitch #(
   parameter int HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  logic din,
   output logic dout
);
   localparam int HW = $clog2(HOLD + 1);

   logic [HW-1:0] run_q;

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("qdec_glitch: HOLD must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= 1'b0;
         run_q <= '0;
      end else if (load) begin
         dout  <= din;
         run_q <= '0;
      end else if (tick) begin
         if (din == dout) begin
            run_q <= '0;
         end else if (run_q == HW'(HOLD - 1)) begin
            dout  <= din;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   AST_FLT_PACED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(dout));  // R5

   AST_FLT_FIRST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && run_q == '0) |=> $stable(dout));  // R4

endmodule

// File: rtl/qdec_channel.sv
module qdec_channel
   import qdec_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int NARROW_W = 8,
   parameter int PORT_W   = 8,
   parameter int HOLD     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [2:0]        src,
   input  logic              wide,
   input  logic              clr,
   input  logic [PORT_W-1:0] pa,
   input  logic [PORT_W-1:0] pb,
   output logic [CNT_W-1:0]  cnt,
   output logic              ovf_evt,
   output logic              unf_evt
);
   localparam int NIB = 4;
   localparam logic [CNT_W-1:0] MASK_N = CNT_W'((1 << NARROW_W) - 1);

   logic [2:0]       src_q;
   logic             resync;
   logic             enabled;
   logic [PORT_W-1:0] port_sel;
   logic [NIB-1:0]   nib;
   logic [1:0]       raw_iq, flt_iq, prev_iq;
   logic [CNT_W-1:0] mask, cnt_q;
   qd_dir_e          dir;

   generate
      if (PORT_W != 2 * NIB) begin : g_bad_port
         $error("qdec_channel: PORT_W must hold two nibbles");
      end
   endgenerate

   assign enabled  = src[2];
   assign resync   = (src != src_q);
   assign port_sel = src[1] ? pb : pa;
   assign nib      = src[0] ? port_sel[2*NIB-1:NIB] : port_sel[NIB-1:0];
   // Disabled: feed the filter its own output so it holds
   assign raw_iq   = enabled ? {nib[1], nib[0]} : flt_iq;

   for (genvar b = 0; b < 2; b++) begin : g_flt
      qdec_glitch #(.HOLD(HOLD)) i_flt (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick),
         .load (resync),
         .din  (raw_iq[b]),
         .dout (flt_iq[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= 3'b000;
         prev_iq <= 2'b00;
      end else begin
         src_q   <= src;
         prev_iq <= resync ? raw_iq : flt_iq;
      end
   end

   always_comb begin
      dir = gray_dir(prev_iq, flt_iq);
      if (!enabled || resync) dir = DIR_NONE;
   end

   assign mask    = wide ? '1 : MASK_N;
   assign ovf_evt = !clr && (dir == DIR_UP)   && ((cnt_q & mask) == mask);
   assign unf_evt = !clr && (dir == DIR_DOWN) && ((cnt_q & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr)               cnt_q <= '0;
      else if (dir == DIR_UP)     cnt_q <= (cnt_q + 1'b1) & mask;
      else if (dir == DIR_DOWN)   cnt_q <= (cnt_q - 1'b1) & mask;
      else                        cnt_q <= cnt_q & mask;
   end

   assign cnt = cnt_q;

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (!$stable(wide) || cnt_q == $past(cnt_q)
                || cnt_q == (($past(cnt_q) + 1'b1) & mask)
                || cnt_q == (($past(cnt_q) - 1'b1) & mask)));  // R2

   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && !clr) |=> (!$stable(wide) || $stable(cnt_q)));  // R10

   AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |=> (wide || (cnt_q & ~MASK_N) == '0));  // R6

endmodule

// File: rtl/qdec_top.sv
module qdec_top
   import qdec_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int NARROW_W = 8,
   parameter int TC_W     = 8,
   parameter int PORT_W   = 8,
   parameter int SYNC_N   = 2,
   parameter int HOLD     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_a,
   input  logic [PORT_W-1:0] port_b,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq
);
   localparam int N_CH  = 2;
   localparam int ST_W  = 2 * N_CH;
   localparam int HI_W  = CNT_W - NARROW_W;
   localparam logic [2:0] A_CSR = 3'd0, A_CFG = 3'd1, A_TC = 3'd2;

   generate
      if (NARROW_W != 8)                 begin : g_bad_nw  $error("qdec_top: NARROW_W must be 8");  end
      if (HI_W < 1 || HI_W > 8)          begin : g_bad_cw  $error("qdec_top: CNT_W out of range"); end
      if (TC_W < 1 || TC_W > 8)          begin : g_bad_tc  $error("qdec_top: TC_W out of range");  end
      if (SYNC_N < 2)                    begin : g_bad_sy  $error("qdec_top: SYNC_N must be >= 2"); end
   endgenerate

   // Input synchronisers
   logic [PORT_W-1:0] sa [SYNC_N];
   logic [PORT_W-1:0] sb [SYNC_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_N; s++) begin
            sa[s] <= '0;
            sb[s] <= '0;
         end
      end else begin
         sa[0] <= port_a;
         sb[0] <= port_b;
         for (int s = 1; s < SYNC_N; s++) begin
            sa[s] <= sa[s-1];
            sb[s] <= sb[s-1];
         end
      end
   end

   // Registers
   logic [6:0]      cfg_q;
   logic [TC_W-1:0] tc_q;
   logic [ST_W-1:0] st_q, evt;
   logic            csr_rd, csr_wr, tick;
   logic [CNT_W-1:0] cnt [N_CH];

   assign csr_rd = reg_rd && (reg_addr == A_CSR);
   assign csr_wr = reg_wr && (reg_addr == A_CSR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         tc_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_CFG) cfg_q <= reg_wdata[6:0];
         if (reg_addr == A_TC)  tc_q  <= reg_wdata[TC_W-1:0];
      end
   end

   qdec_tick #(.TC_W(TC_W)) i_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tc   (tc_q),
      .tick (tick)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      qdec_channel #(
         .CNT_W   (CNT_W),
         .NARROW_W(NARROW_W),
         .PORT_W  (PORT_W),
         .HOLD    (HOLD)
      ) i_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .src    (cfg_q[3*c +: 3]),
         .wide   (cfg_q[6]),
         .clr    (csr_wr),
         .pa     (sa[SYNC_N-1]),
         .pb     (sb[SYNC_N-1]),
         .cnt    (cnt[c]),
         .ovf_evt(evt[2*c]),
         .unf_evt(evt[2*c+1])
      );
   end

   // Sticky wrap flags: a new event wins over a clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= '0;
      else if (csr_rd)  st_q <= evt;
      else              st_q <= st_q | evt;
   end

   assign irq = |st_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         3'd0: reg_rdata = 8'(st_q);
         3'd1: reg_rdata = {1'b0, cfg_q};
         3'd2: reg_rdata = 8'(tc_q);
         3'd3: reg_rdata = cnt[0][7:0];
         3'd4: reg_rdata = 8'(cnt[0][CNT_W-1:NARROW_W]);
         3'd5: reg_rdata = cnt[1][7:0];
         3'd6: reg_rdata = 8'(cnt[1][CNT_W-1:NARROW_W]);
         default: reg_rdata = '0;
      endcase
   end

   AST_WRAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> irq);  // R7

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && !(|evt)) |=> (!irq && st_q == '0));  // R8

endmodule

// File: tb/test_qdec_top.sv
module test_qdec_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] port_a = '0, port_b = '0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int checks = 0, errors = 0;
   int pos_a = 0, pos_b = 0;
   bit done = 0;

   always #5 clk = ~clk;

   qdec_top i_qdec_top (
      .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_b(port_b),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [1:0] iq_of(input int p);
      case (p & 3)
         0: iq_of = 2'b00;
         1: iq_of = 2'b10;
         2: iq_of = 2'b11;
         default: iq_of = 2'b01;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic step_a(input int dir, input int settle);
      pos_a += dir;
      port_a[1:0] = iq_of(pos_a);
      wait_clk(settle);
   endtask

   task automatic step_b(input int dir);
      pos_b += dir;
      port_b[1:0] = iq_of(pos_b);
      wait_clk(16);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 irq", irq, 0);
      for (int a = 0; a < 7; a++) begin
         reg_read(3'(a), d);
         check("R1 register", d, 0);
      end
   endtask

   task automatic t_direction;
      logic [7:0] d;
      reg_write(3'd1, 8'b0_110_100);    // ch0 A low, ch1 B low, 8-bit
      wait_clk(8);
      for (int k = 0; k < 5; k++) step_a(1, 16);
      reg_read(3'd3, d); check("R2 forward", d, 5);
      step_a(-1, 16); step_a(-1, 16);
      reg_read(3'd3, d); check("R2 reverse", d, 3);
   endtask

   task automatic t_illegal;
      logic [7:0] d;
      step_a(2, 16);                    // both lines change at once
      reg_read(3'd3, d); check("R3 double change", d, 3);
      step_a(1, 16);
      reg_read(3'd3, d); check("R3 resume", d, 4);
   endtask

   task automatic t_glitch;
      logic [7:0] d;
      reg_write(3'd2, 8'd3);            // sample every 8 clocks
      port_a[1:0] = iq_of(pos_a + 1);
      wait_clk(4);
      port_a[1:0] = iq_of(pos_a);
      wait_clk(40);
      reg_read(3'd3, d); check("R4 short pulse", d, 4);
      step_a(1, 40);
      reg_read(3'd3, d); check("R4 held level", d, 5);
   endtask

   task automatic t_rate;
      logic [7:0] d;
      reg_write(3'd2, 8'd255);          // sample every 512 clocks
      wait_clk(600);
      step_a(1, 300);
      reg_read(3'd3, d); check("R5 slow not yet", d, 5);
      wait_clk(1100);
      reg_read(3'd3, d); check("R5 slow counted", d, 6);
      reg_write(3'd2, 8'd0);
      wait_clk(600);
   endtask

   task automatic t_clear;
      logic [7:0] d;
      reg_write(3'd0, 8'h00);
      reg_read(3'd3, d); check("R9 cleared", d, 0);
   endtask

   task automatic t_wrap8;
      logic [7:0] d;
      step_a(-1, 16);
      reg_read(3'd3, d); check("R6 8-bit low", d, 8'hFF);
      reg_read(3'd4, d); check("R6 8-bit high", d, 0);
      check("R7 irq on underflow", irq, 1);
      reg_read(3'd0, d); check("R7 underflow flag", d, 8'h02);
      check("R8 irq cleared", irq, 0);
      reg_read(3'd0, d); check("R8 flags cleared", d, 0);
      step_a(1, 16);
      reg_read(3'd3, d); check("R7 8-bit to zero", d, 0);
      reg_read(3'd0, d); check("R7 overflow flag", d, 8'h01);
   endtask

   task automatic t_wrap10;
      logic [7:0] d;
      reg_write(3'd1, 8'b1_110_100);
      wait_clk(4);
      step_a(-1, 16);
      reg_read(3'd3, d); check("R6 10-bit low", d, 8'hFF);
      reg_read(3'd4, d); check("R6 10-bit high", d, 8'h03);
      reg_read(3'd0, d); check("R7 10-bit underflow", d, 8'h02);
      step_a(1, 16);
      reg_read(3'd4, d); check("R6 10-bit high back", d, 0);
      reg_read(3'd0, d); check("R7 10-bit overflow", d, 8'h01);
      check("R8 irq low after read", irq, 0);
      reg_write(3'd1, 8'b0_110_100);
      wait_clk(4);
   endtask

   task automatic t_channels;
      logic [7:0] d;
      step_b(1); step_b(1);
      reg_read(3'd5, d); check("R11 ch1 count", d, 2);
      reg_read(3'd3, d); check("R11 ch0 untouched", d, 0);
      step_b(-1); step_b(-1); step_b(-1);
      reg_read(3'd0, d); check("R11 ch1 underflow bit", d, 8'h08);
   endtask

   task automatic t_disable;
      logic [7:0] d;
      step_a(1, 16); step_a(1, 16);
      reg_write(3'd1, 8'b0_110_000);    // ch0 off
      for (int k = 0; k < 3; k++) step_a(1, 16);
      reg_read(3'd3, d); check("R10 held while off", d, 2);
      reg_write(3'd1, 8'b0_110_100);    // back on, input now differs
      wait_clk(20);
      reg_read(3'd3, d); check("R10 no count on exit", d, 2);
      reg_write(3'd1, 8'b0_110_101);    // switch to upper nibble (idle)
      wait_clk(20);
      reg_read(3'd3, d); check("R10 no count on switch", d, 2);
      reg_write(3'd1, 8'b0_110_100);
      wait_clk(20);
      step_a(1, 16);
      reg_read(3'd3, d); check("R10 counts after exit", d, 3);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset;
      t_direction;
      t_illegal;
      t_glitch;
      t_rate;
      t_clear;
      t_wrap8;
      t_wrap10;
      t_channels;
      t_disable;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule